// File: doc/BRIEF.md
# Dual-Channel Receive Sample Formatter

This block sits at the output of a two-converter receive path. It accepts one sample from each channel as a pair, qualified by a single valid strobe, and lays the pair out on the output pins in one of two ways. In parallel layout each channel gets its own bus and both words leave in the same cycle. In interleaved layout the two channels share one bus at twice the word rate: the channel A word goes out first, then the channel B word. A sync flag is high while the channel A word is on the shared bus.

A coding bit selects two's complement or offset binary for the outgoing words. Offset binary is the two's complement word with its most significant bit inverted. The layout bit and the coding bit are captured with each pair and apply to both words of that pair, so a change only takes effect at the next pair boundary. A data clock enable marks every cycle that carries a fresh word.

Top module: `rx_pair_formatter`

## Requirements
- R1: After reset both buses are zero, and sync and the data enable are low.
- R2: In parallel layout (layout bit 0), one cycle after an accepted pair, bus A carries the channel A word, bus B carries the channel B word, the data enable is high and sync is low, for exactly one cycle.
- R3: In interleaved layout (layout bit 1), in the first cycle after an accepted pair bus A carries the channel A word with sync high. In the next cycle bus A carries the channel B word with sync low. The data enable is high in both cycles, and bus B is zero in both.
- R4: With the coding bit at 0 a word leaves unchanged (two's complement). With the coding bit at 1, bit 11 (the most significant bit) is inverted and bits 10 to 0 are unchanged (offset binary).
- R5: The layout and coding bits are sampled together with the pair. A change made while the channel B word of an interleaved pair is pending does not alter that word.
- R6: A valid strobe that arrives in the cycle where the channel B word of an interleaved pair is being sent is ignored, and that pair is never output.
- R7: In a cycle with no new word the data enable is low and both buses hold their previous values.
- R8: In parallel layout, pairs on consecutive cycles are output on consecutive cycles with none lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample pair is present on in_a and in_b |
| in_a | input | 12 | Channel A sample, two's complement |
| in_b | input | 12 | Channel B sample, two's complement |
| lay_interleave | input | 1 | 0 parallel layout, 1 interleaved layout |
| code_offset | input | 1 | 0 two's complement, 1 offset binary |
| bus_a | output | 12 | Channel A bus, or the shared bus when interleaved |
| bus_b | output | 12 | Channel B bus, zero when interleaved |
| sync | output | 1 | High while the channel A word is on the shared bus |
| data_ce | output | 1 | A fresh word is on the output in this cycle |

## Verification
The assertions take for granted only that reset is applied before the first pair and that inputs carry known values. They make no assumption on the spacing of valid strobes, since a strobe during a pending channel B slot is defined to be dropped. The stimulus normally leaves one idle cycle after each interleaved pair. On purpose, it strobes once inside a channel B slot, with the layout and coding bits flipped at the same time, to exercise both the drop rule and the pair-boundary rule.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic {
    LAYOUT_PARALLEL   = 1'b0,
    LAYOUT_INTERLEAVE = 1'b1
  } layout_e;

  typedef enum logic {
    CODE_TWOS   = 1'b0,
    CODE_OFFSET = 1'b1
  } coding_e;

  localparam int unsigned LANES = 3;  // incoming A, incoming B, held B
endpackage

// File: rtl/rxf_coder.sv
module rxf_coder #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] x,
  input  logic         offset,
  output logic [W-1:0] y
);
  function automatic logic [W-1:0] recode(input logic [W-1:0] v, input logic off);
    return {v[W-1] ^ off, v[W-2:0]};
  endfunction

  assign y = recode(x, offset);
endmodule

// File: rtl/rxf_pair_capture.sv
module rxf_pair_capture #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_b,
  input  logic         lay_interleave,
  input  logic         code_offset,
  output logic         take,
  output logic         emit_b,
  output logic [W-1:0] held_b,
  output logic         held_offset
);
  logic pend_b;

  assign emit_b = pend_b;
  assign take   = in_valid & ~pend_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_b      <= 1'b0;
      held_b      <= '0;
      held_offset <= 1'b0;
    end else begin
      pend_b <= take & lay_interleave;
      if (take) begin
        held_b      <= in_b;
        held_offset <= code_offset;
      end
    end
  end
endmodule

// File: rtl/rxf_out_stage.sv
module rxf_out_stage #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic         emit_b,
  input  logic         interleave,
  input  logic [W-1:0] word_a,
  input  logic [W-1:0] word_b,
  input  logic [W-1:0] word_held,
  output logic [W-1:0] bus_a,
  output logic [W-1:0] bus_b,
  output logic         sync,
  output logic         data_ce
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_a   <= '0;
      bus_b   <= '0;
      sync    <= 1'b0;
      data_ce <= 1'b0;
    end else if (emit_b) begin
      bus_a   <= word_held;
      bus_b   <= '0;
      sync    <= 1'b0;
      data_ce <= 1'b1;
    end else if (take) begin
      bus_a   <= word_a;
      bus_b   <= interleave ? '0 : word_b;
      sync    <= interleave;
      data_ce <= 1'b1;
    end else begin
      sync    <= 1'b0;
      data_ce <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_pair_formatter.sv
module rx_pair_formatter #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic         lay_interleave,
  input  logic         code_offset,
  output logic [W-1:0] bus_a,
  output logic [W-1:0] bus_b,
  output logic         sync,
  output logic         data_ce
);
  import rxf_pkg::*;

  logic         take;
  logic         emit_b;
  logic [W-1:0] held_b;
  logic         held_offset;
  layout_e      layout;

  logic [W-1:0] lane_in  [LANES];
  logic         lane_off [LANES];
  logic [W-1:0] lane_out [LANES];

  assign layout = layout_e'(lay_interleave);

  rxf_pair_capture #(.W(W)) u_cap (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_b           (in_b),
    .lay_interleave (lay_interleave),
    .code_offset    (code_offset),
    .take           (take),
    .emit_b         (emit_b),
    .held_b         (held_b),
    .held_offset    (held_offset)
  );

  assign lane_in[0]  = in_a;
  assign lane_off[0] = code_offset;
  assign lane_in[1]  = in_b;
  assign lane_off[1] = code_offset;
  assign lane_in[2]  = held_b;
  assign lane_off[2] = held_offset;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    rxf_coder #(.W(W)) u_coder (
      .x      (lane_in[g]),
      .offset (lane_off[g]),
      .y      (lane_out[g])
    );
  end

  rxf_out_stage #(.W(W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .emit_b     (emit_b),
    .interleave (layout == LAYOUT_INTERLEAVE),
    .word_a     (lane_out[0]),
    .word_b     (lane_out[1]),
    .word_held  (lane_out[2]),
    .bus_a      (bus_a),
    .bus_b      (bus_b),
    .sync       (sync),
    .data_ce    (data_ce)
  );
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int unsigned W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic         lay_interleave,
  input logic         code_offset,
  input logic [W-1:0] bus_a,
  input logic [W-1:0] bus_b,
  input logic         sync,
  input logic         data_ce,
  input logic         take,
  input logic         emit_b
);
  AST_PAR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    take && !lay_interleave |=> data_ce && !sync && bus_b[W-2:0] == $past(in_b[W-2:0])); // R2
  AST_INT_A_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    take && lay_interleave |=> sync && data_ce && bus_b == '0); // R3
  AST_INT_B_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> data_ce && !sync && bus_b == '0); // R3
  AST_CODE_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> bus_a[W-1] == ($past(in_a[W-1]) ^ $past(code_offset)) && bus_a[W-2:0] == $past(in_a[W-2:0])); // R4
  AST_SYNC_WITH_CE: assert property (@(posedge clk) disable iff (!rst_n)
    sync |-> data_ce); // R3
  AST_B_SLOT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    emit_b && in_valid |=> !sync); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !data_ce |-> $stable(bus_a) && $stable(bus_b)); // R7
  AST_PAR_BACK2BACK: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !emit_b |=> data_ce); // R8
endmodule

bind rx_pair_formatter rxf_checker #(.W(W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .in_a           (in_a),
  .in_b           (in_b),
  .lay_interleave (lay_interleave),
  .code_offset    (code_offset),
  .bus_a          (bus_a),
  .bus_b          (bus_b),
  .sync           (sync),
  .data_ce        (data_ce),
  .take           (take),
  .emit_b         (emit_b)
);

// File: tb/rx_pair_formatter_test.sv
module rx_pair_formatter_test;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic         lay_interleave = 1'b0;
  logic         code_offset = 1'b0;
  logic [W-1:0] bus_a, bus_b;
  logic         sync, data_ce;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         s;
    string        req;
  } exp_t;

  exp_t sb[$];

  always #5 clk = ~clk;

  rx_pair_formatter #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .lay_interleave(lay_interleave), .code_offset(code_offset),
    .bus_a(bus_a), .bus_b(bus_b), .sync(sync), .data_ce(data_ce)
  );

  // offset binary = two's complement with the top bit flipped
  function automatic logic [W-1:0] expect_code(input logic [W-1:0] v, input logic off);
    return off ? (v ^ 12'h800) : v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // driver: present one pair for one cycle and queue the expected words
  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic lay, input logic off, input string req);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b; lay_interleave = lay; code_offset = off;
    if (lay) begin
      e.a = expect_code(a, off); e.b = '0; e.s = 1'b1; e.req = req; sb.push_back(e);
      e.a = expect_code(b, off); e.b = '0; e.s = 1'b0; e.req = req; sb.push_back(e);
    end else begin
      e.a = expect_code(a, off); e.b = expect_code(b, off); e.s = 1'b0; e.req = req;
      sb.push_back(e);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor
  logic [W-1:0] last_a = '0, last_b = '0;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !done) begin
        if (data_ce) begin
          if (sb.size() == 0) begin
            check(1'b0, "R6", "unexpected word", bus_a, '0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            check(bus_a == e.a, e.req, "bus_a", bus_a, e.a);
            check(bus_b == e.b, e.req, "bus_b", bus_b, e.b);
            check(sync == e.s, e.req, "sync", {11'b0, sync}, {11'b0, e.s});
          end
        end else begin
          check(bus_a == last_a && bus_b == last_b && !sync, "R7", "idle hold", bus_a, last_a);
        end
        last_a = bus_a;
        last_b = bus_b;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(bus_a == '0 && bus_b == '0, "R1", "reset buses", bus_a | bus_b, '0);
    check(!sync && !data_ce, "R1", "reset flags", {10'b0, sync, data_ce}, '0);
    rst_n = 1'b1;

    // R2 / R4: parallel, both codings
    send(12'h123, 12'h9AB, 1'b0, 1'b0, "R2");
    idle(2);
    send(12'h800, 12'h7FF, 1'b0, 1'b1, "R4");
    idle(2);
    send(12'hFFF, 12'h000, 1'b0, 1'b1, "R4");
    idle(1);

    // R8: consecutive parallel pairs
    send(12'h001, 12'h002, 1'b0, 1'b0, "R8");
    send(12'h003, 12'h004, 1'b0, 1'b1, "R8");
    send(12'h005, 12'h006, 1'b0, 1'b0, "R8");
    idle(2);

    // R3: interleaved, A then B
    send(12'hA5A, 12'h5A5, 1'b1, 1'b0, "R3");
    idle(1);
    send(12'h0F0, 12'hF0F, 1'b1, 1'b1, "R3");
    idle(2);

    // R5 + R6: strobe inside the B slot with layout and coding flipped
    send(12'h321, 12'h456, 1'b1, 1'b0, "R5");
    @(negedge clk);
    in_valid = 1'b1; in_a = 12'hEEE; in_b = 12'hDDD; lay_interleave = 1'b0; code_offset = 1'b1;
    idle(3);
    check(sb.size() == 0, "R6", "dropped pair left no entry", 12'(sb.size()), '0);

    // R5: a later pair follows the new settings
    send(12'h100, 12'h200, 1'b0, 1'b1, "R5");
    idle(3);

    check(sb.size() == 0, "R2", "all words delivered", 12'(sb.size()), '0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule